// File: doc/BRIEF.md
# Fractional Rate Tick Generator

This block raises a one-clock tick at a programmable fraction of its clock rate. It holds a down-counting accumulator that starts at a programmed period value. On every clock the accumulator drops by a programmed increment. When the next subtraction would reach or cross zero, the block emits a tick. It then adds the period back while keeping the leftover remainder. Over any whole number of periods, the average tick rate is therefore exactly increment/period of the clock rate.

Configuration writes go to pending registers through a small write port. A new period or increment first takes effect at the next wrap, so a running sequence is never disturbed in the middle of a period. A synchronous restart pulse applies the pending values at once and starts the sequence again from a full period.

Top module: `frac_rate_gen`

## Requirements
- R1: After synchronous reset the tick is low, the period is DEF_START (10) and the increment is DEF_STEP (3). The first tick after reset is high in the cycle after the 4th rising edge following reset release, and low after the 5th.
- R2: While the accumulator is above the active increment, each clock lowers it by exactly that increment and leaves the tick low. The accumulator is never zero.
- R3: When the accumulator is at or below the active increment, the next clock raises the tick for that cycle. The new accumulator value is old - increment + period, so the remainder is kept. Starting from a restart, exactly periods*increment ticks occur in periods*period clocks when increment ≤ period.
- R4: With an increment of zero, no tick is ever produced.
- R5: With an increment equal to or greater than the period, the tick is high on every clock. When old + period ≤ increment, the accumulator reloads to the period.
- R6: A write with wr_sel=0 sets the pending period and a write with wr_sel=1 sets the pending increment. Pending values reach the active state only at the next wrap or restart.
- R7: A restart pulse loads the accumulator with the pending period, makes the pending increment active, and forces the tick low in the following cycle.
- R8: A write of zero to the period is ignored, and the previous pending period is kept.
- R9: Reset overrides a running sequence and returns the block to its R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 1 | Write target: 0 period, 1 increment |
| wr_data | input | W | Value to write |
| restart | input | 1 | Synchronous restart, applies pending values now |
| tick_o | output | 1 | Registered rate tick |

## Verification
The main function is driven with period/increment pairs that each separate one kind of fault:
- a coprime pair checks that the remainder is kept;
- equal values check the every-cycle case;
- a zero increment checks that no tick is produced;
- an increment of one checks long runs between ticks;
- an increment above the period checks the reload clamp.

For each pair, ticks are counted over a whole number of periods. Any fault in the remainder handling shifts the count away from periods*increment. Directed sequences then place single ticks at known edges to tell apart three timing choices: deferred and immediate application of new values, restart clearing, and reset in the middle of a run.

// File: rtl/frac_pkg.sv
package frac_pkg;
  typedef enum logic {
    SEL_START = 1'b0,
    SEL_STEP  = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/frac_cfg_regs.sv
module frac_cfg_regs #(
  parameter int W         = 16,
  parameter int DEF_START = 10,
  parameter int DEF_STEP  = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         apply,
  output logic [W-1:0] pend_start_o,
  output logic [W-1:0] pend_step_o,
  output logic [W-1:0] act_step_o
);
  import frac_pkg::*;

  localparam logic [W-1:0] RST_START = W'(DEF_START);
  localparam logic [W-1:0] RST_STEP  = W'(DEF_STEP);

  logic start_wr, step_wr;

  always_comb begin
    start_wr = wr_en && (cfg_sel_e'(wr_sel) == SEL_START) && (wr_data != '0);
    step_wr  = wr_en && (cfg_sel_e'(wr_sel) == SEL_STEP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_start_o <= RST_START;
      pend_step_o  <= RST_STEP;
    end else begin
      if (start_wr) pend_start_o <= wr_data;
      if (step_wr)  pend_step_o  <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        act_step_o <= RST_STEP;
    else if (apply) act_step_o <= pend_step_o;
  end
endmodule

// File: rtl/frac_accum.sv
module frac_accum #(
  parameter int W         = 16,
  parameter int DEF_START = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic [W-1:0] step_i,
  input  logic [W-1:0] start_i,
  output logic [W-1:0] acc_o,
  output logic         wrap_o
);
  localparam int           XW        = W + 1;
  localparam logic [W-1:0] RST_START = W'(DEF_START);

  logic [XW-1:0] sum_x, left_x;
  logic [W-1:0]  reload_v, acc_nxt;
  logic          at_edge;

  always_comb begin
    at_edge  = (acc_o <= step_i);
    sum_x    = {1'b0, acc_o} + {1'b0, start_i};
    left_x   = sum_x - {1'b0, step_i};
    reload_v = (sum_x > {1'b0, step_i}) ? left_x[W-1:0] : start_i;
    acc_nxt  = at_edge ? reload_v : (acc_o - step_i);
    wrap_o   = at_edge && !restart;
  end

  always_ff @(posedge clk) begin
    if (rst)          acc_o <= RST_START;
    else if (restart) acc_o <= start_i;
    else              acc_o <= acc_nxt;
  end
endmodule

// File: rtl/frac_tick_reg.sv
module frac_tick_reg (
  input  logic clk,
  input  logic rst,
  input  logic wrap_i,
  output logic tick_o
);
  always_ff @(posedge clk) begin
    if (rst) tick_o <= 1'b0;
    else     tick_o <= wrap_i;
  end
endmodule

// File: rtl/frac_rate_gen.sv
module frac_rate_gen #(
  parameter int W         = 16,
  parameter int DEF_START = 10,
  parameter int DEF_STEP  = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         restart,
  output logic         tick_o
);
  logic [W-1:0] pend_start, pend_step, act_step, acc_q;
  logic         wrap, apply;

  assign apply = wrap | restart;

  frac_cfg_regs #(.W(W), .DEF_START(DEF_START), .DEF_STEP(DEF_STEP)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .apply(apply), .pend_start_o(pend_start), .pend_step_o(pend_step),
    .act_step_o(act_step)
  );

  frac_accum #(.W(W), .DEF_START(DEF_START)) u_acc (
    .clk(clk), .rst(rst), .restart(restart), .step_i(act_step),
    .start_i(pend_start), .acc_o(acc_q), .wrap_o(wrap)
  );

  frac_tick_reg u_tick (
    .clk(clk), .rst(rst), .wrap_i(wrap), .tick_o(tick_o)
  );
endmodule

// File: rtl/frac_rate_gen_chk.sv
module frac_rate_gen_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         restart,
  input logic         wr_en,
  input logic         wr_sel,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] acc,
  input logic [W-1:0] act_step,
  input logic [W-1:0] pend_start,
  input logic         tick
);
  AST_ACC_NONZERO: assert property (@(posedge clk) disable iff (rst)
    acc != '0); // R2
  AST_DEC_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (!restart && acc > act_step) |=> (!tick && acc == $past(acc) - $past(act_step))); // R2
  AST_WRAP_TICK: assert property (@(posedge clk) disable iff (rst)
    (!restart && acc <= act_step) |=> tick); // R3
  AST_STEP0_SILENT: assert property (@(posedge clk) disable iff (rst)
    (!restart && act_step == '0) |=> !tick); // R4
  AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!tick && acc == $past(pend_start))); // R7
  AST_ZERO_START_IGN: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel && wr_data == '0) |=> $stable(pend_start)); // R8
endmodule

bind frac_rate_gen frac_rate_gen_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .restart(restart), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .acc(acc_q), .act_step(act_step),
  .pend_start(pend_start), .tick(tick_o)
);

// File: tb/frac_rate_gen_tb.sv
module frac_rate_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int NV = 7;
  localparam int V_START [NV] = '{10, 7, 16, 9, 100, 13, 5};
  localparam int V_STEP  [NV] = '{ 3, 7,  5, 0,  37,  1, 8};
  localparam int V_PER   [NV] = '{ 5, 2,  4, 3,   3,  6, 2};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic wr_sel = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic restart = 1'b0;
  logic tick_o;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  frac_rate_gen #(.W(W), .DEF_START(10), .DEF_STEP(3)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .restart(restart), .tick_o(tick_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual cycles %0d expected below 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edge1();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input int val);
    wr_en = 1'b1; wr_sel = sel; wr_data = W'(val);
    edge1();
    wr_en = 1'b0;
  endtask

  task automatic pulse_restart();
    restart = 1'b1;
    edge1();
    restart = 1'b0;
  endtask

  task automatic count_ticks(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      edge1();
      if (tick_o) cnt++;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    edge1();
    edge1();
    rst = 1'b0;
  endtask

  task automatic default_sequence(input string req);
    for (int e = 1; e <= 5; e++) begin
      edge1();
      chk(req, int'(tick_o), (e == 4) ? 1 : 0);
    end
  endtask

  initial begin
    int cnt;
    int exp;
    @(negedge clk);
    do_reset();
    chk("R1 reset tick low", int'(tick_o), 0);
    default_sequence("R1 default first tick");

    // table of pairs: R3 exact count, R4 zero step, R5 step >= start
    for (int v = 0; v < NV; v++) begin
      wr(1'b0, V_START[v]);
      wr(1'b1, V_STEP[v]);
      pulse_restart();
      chk("R7 restart tick low", int'(tick_o), 0);
      count_ticks(V_PER[v] * V_START[v], cnt);
      exp = (V_STEP[v] >= V_START[v]) ? V_PER[v] * V_START[v] : V_PER[v] * V_STEP[v];
      if (V_STEP[v] == 0)                 chk("R4 no tick with zero step", cnt, exp);
      else if (V_STEP[v] >= V_START[v])   chk("R5 tick every cycle", cnt, exp);
      else                                chk("R3 exact tick count", cnt, exp);
    end

    // R6: new step deferred to the next wrap
    wr(1'b0, 10);
    wr(1'b1, 3);
    pulse_restart();              // acc = 10, step 3
    wr(1'b1, 0);                  // edge1: 10 -> 7
    edge1(); chk("R6 old step kept", int'(tick_o), 0);  // 7 -> 4
    edge1(); chk("R6 old step kept", int'(tick_o), 0);  // 4 -> 1
    edge1(); chk("R6 wrap with old step", int'(tick_o), 1);
    count_ticks(40, cnt);
    chk("R6 new step after wrap", cnt, 0);

    // R7: restart applies pending values immediately
    wr(1'b0, 20);
    wr(1'b1, 1);
    pulse_restart();
    count_ticks(19, cnt);
    chk("R7 no tick before 20th edge", cnt, 0);
    edge1();
    chk("R7 tick at 20th edge", int'(tick_o), 1);
    edge1();
    chk("R2 tick one clock wide", int'(tick_o), 0);

    // R7: restart clears a running tick
    wr(1'b0, 4);
    wr(1'b1, 4);
    pulse_restart();
    edge1();
    chk("R5 tick high with equal values", int'(tick_o), 1);
    pulse_restart();
    chk("R7 restart clears tick", int'(tick_o), 0);

    // R8: zero period write ignored
    wr(1'b0, 6);
    wr(1'b1, 2);
    wr(1'b0, 0);
    pulse_restart();
    count_ticks(12, cnt);
    chk("R8 zero period ignored", cnt, 4);

    // R9: reset in the middle of a run
    wr(1'b0, 4);
    wr(1'b1, 4);
    pulse_restart();
    edge1();
    rst = 1'b1;
    edge1();
    chk("R9 reset clears tick", int'(tick_o), 0);
    rst = 1'b0;
    default_sequence("R9 defaults after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule